// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block drives the digital side of a 12-bit successive-approximation converter. A start request, sampled on a falling edge of the conversion clock while the block is idle, freezes the track/hold and begins a fixed thirteen-cycle sequence. In each of the first twelve cycles the block presents a trial code to an external DAC. On the next falling edge it reads back a single comparator bit, deciding the code from the most significant bit down. The thirteenth cycle ends the conversion. It latches the result and returns the busy indication to its idle level.

The result is straight binary in unipolar mode. In bipolar mode it is offset binary, formed by inverting the top bit. The mode is captured when the conversion starts. The track/hold returns to tracking only after the conversion has finished and the host deselects the block. All state moves on the falling edge of the conversion clock, so the comparator settles during the high phase that precedes each decision.

Top module: `sar_seq_top`

## Requirements
- R1: While rst_ni is low, busy_no is 1, hold_o is 0, and both result_o and dac_code_o are 0.
- R2: start_i high at a falling edge while busy_no is 1 drives busy_no to 0 and hold_o to 1 after that edge.
- R3: busy_no stays 0 for exactly 13 falling-edge samples after the launch edge. On the 13th falling edge after launch, busy_no returns to 1 and result_o takes the new code.
- R4: start_i pulses while busy_no is 0 are ignored: they neither stretch the conversion nor change its result.
- R5: The first trial code after launch is 0x800. In cycle k (k = 1..12), bit 12-k is kept when cmp_i is 1 at the closing falling edge and cleared otherwise, and bit 11-k is then set as the next trial. So in cycle 2 dac_code_o equals the decided bit 11 with 0x400 added.
- R6: In unipolar mode (bipolar_i = 0 at launch), result_o is the straight-binary SAR code. With an ideal comparator that trips half an LSB below each DAC level, an input of 0.5 LSB gives 0x001 and full scale minus 1.5 LSB gives 0xFFF.
- R7: When bipolar_i is 1 at launch, result_o equals the SAR code with bit 11 inverted. Changes on bipolar_i after launch have no effect on that conversion.
- R8: hold_o stays 1 after a conversion until a falling edge sees desel_i = 1 with busy_no = 1. hold_o then falls after that edge. desel_i during a conversion does not release it.
- R9: result_o changes only on the edge where busy_no returns to 1, and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock; all state moves on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled on falling edges while idle |
| bipolar_i | input | 1 | Output coding select, captured at launch (1 = offset binary) |
| desel_i | input | 1 | Host deselect; releases the track/hold once idle |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | 12 | Trial code for the DAC |
| busy_no | output | 1 | Low while a conversion runs |
| hold_o | output | 1 | High while the track/hold holds |
| result_o | output | 12 | Last converted code |

## Verification
The bound checker enforces the timing skeleton on every edge. Busy may only fall after a start request, and it must stay low for exactly thirteen samples. Hold must be high throughout busy, it may only release when idle and deselected, and the result may only move when busy rises. The bench's comparator model is the only way to show that the SAR decisions, the half-LSB transfer corners and the bipolar MSB flip are correct. The same goes for a second start that is ignored and for a mode change in mid-conversion that has no effect.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned DEF_WIDTH = 12;

  // one-hot mask of the top bit of a W-bit code
  function automatic logic [31:0] top_mask(input int unsigned w);
    return 32'(1) << (w - 1);
  endfunction
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned LAST  = WIDTH + 1,
  localparam int unsigned CNT_W = $clog2(LAST + 1),
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             desel_i,
  output logic             active_o,
  output logic             launch_o,
  output logic             decide_o,
  output logic             done_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             hold_o
);
  logic             active_q, hold_q;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] rem;

  assign launch_o = !active_q && start_i;
  assign decide_o = active_q && (step_q <= CNT_W'(WIDTH));
  assign done_o   = active_q && (step_q == CNT_W'(LAST));
  assign rem      = CNT_W'(WIDTH) - step_q;
  assign bit_idx_o = rem[IDX_W-1:0];
  assign active_o = active_q;
  assign hold_o   = hold_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (launch_o) begin
      active_q <= 1'b1;
      step_q   <= CNT_W'(1);
    end else if (done_o) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (active_q) begin
      step_q   <= step_q + CNT_W'(1);
    end
  end

  // track/hold: hold from launch until idle and deselected
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= 1'b0;
    else if (launch_o)               hold_q <= 1'b1;
    else if (!active_q && desel_i)   hold_q <= 1'b0;
  end
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             decide_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o
);
  localparam logic [WIDTH-1:0] FIRST_TRIAL = WIDTH'(top_mask(WIDTH));

  logic [WIDTH-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    for (int i = 0; i < WIDTH; i++) begin
      if (IDX_W'(i) == bit_idx_i)            code_d[i] = cmp_i;
      if (i + 1 < WIDTH && IDX_W'(i + 1) == bit_idx_i) code_d[i] = 1'b1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (launch_i) code_q <= FIRST_TRIAL;
    else if (decide_i) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             done_i,
  input  logic             bipolar_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] MSB_MASK = WIDTH'(top_mask(WIDTH));

  logic             bip_q;
  logic [WIDTH-1:0] result_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bip_q <= 1'b0;
    else if (launch_i) bip_q <= bipolar_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (done_i) result_q <= bip_q ? (code_i ^ MSB_MASK) : code_i;
  end

  assign result_o = result_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bipolar_i,
  input  logic             desel_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_no,
  output logic             hold_o,
  output logic [WIDTH-1:0] result_o
);
  logic             active, launch, decide, done;
  logic [IDX_W-1:0] bit_idx;
  logic [WIDTH-1:0] code;

  sar_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .desel_i(desel_i),
    .active_o(active), .launch_o(launch), .decide_o(decide), .done_o(done),
    .bit_idx_o(bit_idx), .hold_o(hold_o)
  );

  sar_seq_reg #(.WIDTH(WIDTH)) reg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .decide_i(decide),
    .bit_idx_i(bit_idx), .cmp_i(cmp_i), .code_o(code)
  );

  sar_seq_out #(.WIDTH(WIDTH)) out_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .done_i(done),
    .bipolar_i(bipolar_i), .code_i(code), .result_o(result_o)
  );

  assign dac_code_o = code;
  assign busy_no    = !active;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned WIDTH = 12,
  localparam int unsigned CW = $clog2(WIDTH + 4)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             desel_i,
  input logic             busy_no,
  input logic             hold_o,
  input logic [WIDTH-1:0] result_o
);
  logic [CW-1:0] low_cnt;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                low_cnt <= '0;
    else if (busy_no)                           low_cnt <= '0;
    else if (low_cnt != CW'(WIDTH + 3))         low_cnt <= low_cnt + CW'(1);
  end

  // R2
  busy_needs_start_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> $past(start_i));

  // R3
  conv_len_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> low_cnt == CW'(WIDTH + 1));

  // R4
  no_stretch_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !busy_no |-> low_cnt <= CW'(WIDTH));

  // R8
  hold_in_conv_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !busy_no |-> hold_o);

  // R8
  hold_release_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(desel_i) && $past(busy_no));

  // R9
  result_move_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $rose(busy_no));
endmodule

bind sar_seq_top sar_seq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .desel_i(desel_i),
  .busy_no(busy_no), .hold_o(hold_o), .result_o(result_o)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bipolar = 1'b0, desel = 1'b1;
  logic        cmp;
  logic [11:0] dac_code, result;
  logic        busy_n, hold;
  int          vin2 = 0;       // analog input in half-LSB units
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  // ideal comparator: trips half an LSB below each DAC level
  assign cmp = (vin2 >= 2 * int'(dac_code) - 1);

  sar_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bipolar_i(bipolar),
    .desel_i(desel), .cmp_i(cmp), .dac_code_o(dac_code), .busy_no(busy_n),
    .hold_o(hold), .result_o(result)
  );

  function automatic int exp_code(input int v2, input bit bip);
    int c = (v2 + 1) >> 1;
    if (c > 4095) c = 4095;
    return bip ? (c ^ 'h800) : c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic convert(input int v2, input bit bip, input bit restart, input bit keep_sel);
    int e = exp_code(v2, 1'b0);
    int prev = int'(result);
    int lows = 2;
    @(posedge clk);
    vin2 = v2; bipolar = bip; start = 1'b1;
    if (keep_sel) desel = 1'b0;
    @(posedge clk);                 // P1
    start = 1'b0;
    chk(busy_n == 1'b0, "R2 busy", int'(busy_n), 0);
    chk(hold == 1'b1, "R2 hold", int'(hold), 1);
    chk(dac_code == 12'h800, "R5 first trial", int'(dac_code), 'h800);
    chk(int'(result) == prev, "R9 result held", int'(result), prev);
    @(posedge clk);                 // P2
    chk(int'(dac_code) == ((e & 'h800) | 'h400), "R5 second trial", int'(dac_code), (e & 'h800) | 'h400);
    if (restart) start = 1'b1;      // R4: ignored while busy
    bipolar = ~bip;                 // R7: must not affect this conversion
    @(posedge clk);                 // P3
    start = 1'b0;
    while (busy_n === 1'b0 && lows < 40) begin
      lows++;
      @(posedge clk);
    end
    chk(lows == 13, restart ? "R4 length" : "R3 length", lows, 13);
    chk(int'(result) == exp_code(v2, bip), bip ? "R7 result" : "R6 result",
        int'(result), exp_code(v2, bip));
    chk(hold == 1'b1, "R8 hold at end", int'(hold), 1);
    if (keep_sel) begin
      repeat (2) @(posedge clk);
      chk(hold == 1'b1, "R8 hold while selected", int'(hold), 1);
      desel = 1'b1;
    end
    @(posedge clk);
    chk(hold == 1'b0, "R8 release", int'(hold), 0);
  endtask

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    chk(busy_n == 1'b1, "R1 busy", int'(busy_n), 1);
    chk(hold == 1'b0, "R1 hold", int'(hold), 0);
    chk(result == 12'h0, "R1 result", int'(result), 0);
    chk(dac_code == 12'h0, "R1 dac", int'(dac_code), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    convert(0, 1'b0, 1'b0, 1'b0);       // R6 zero
    convert(1, 1'b0, 1'b0, 1'b0);       // R6 0.5 LSB -> 001
    convert(8188, 1'b0, 1'b0, 1'b0);    // R6 FFE
    convert(8189, 1'b0, 1'b0, 1'b0);    // R6 FS-1.5 LSB -> FFF
    convert(8191, 1'b0, 1'b0, 1'b0);    // R6 clip
    convert(4095, 1'b1, 1'b0, 1'b0);    // R7 mid scale
    convert(0, 1'b1, 1'b0, 1'b0);       // R7 negative end
    convert(3000, 1'b0, 1'b1, 1'b0);    // R4 second start ignored
    convert(5555, 1'b1, 1'b0, 1'b1);    // R8 stays held until deselect

    seed = int'($urandom(32'd1913));
    for (int n = 0; n < 30; n++) begin
      convert(int'($urandom_range(8191, 0)), 1'($urandom_range(1, 0)),
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule